// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two predictors side by side and a third table picks one of them. The local predictor keeps a short history for each branch. It reads a history table with a hash of the fetch address, then uses that history to pick a 3-bit saturating counter. The global predictor keeps one shift register holding the outcomes of the most recent resolved branches. That register selects a 2-bit saturating counter. A table of 2-bit choice counters, selected by the same global history, decides which of the two predictions the block returns.

The fetch stage raises `pred_req` with a fetch address. One clock later the block returns the final prediction and both component predictions. The pipeline keeps the two component bits with the branch. When the branch resolves, the pipeline returns them with the branch address and the real outcome, and every table is trained. A context-switch strobe clears every table and the global history in one cycle.

Top module: `bp_tournament`

## Requirements
- R1: `pred_valid` is 1 exactly one cycle after a cycle with `pred_req` high, and 0 one cycle after a cycle with `pred_req` low.
- R2: The local history table has 2^LHT_IDX_W entries of LHIST_W bits. Its index is the fetch address folded by XOR: address bit i goes into index bit (i mod LHT_IDX_W). On resolve, the outcome (1 = taken) is shifted into bit 0 of that branch's entry and the oldest bit is dropped.
- R3: The local history read for a fetch address selects one of 2^LHIST_W counters, each LCNT_W bits wide. The counter's most significant bit is `pred_local`. On resolve, the counter selected by the branch's current history moves up on taken and down on not taken.
- R4: The global history register selects one of 2^GHIST_W counters, each GCNT_W bits wide. That counter's most significant bit is `pred_global`. On resolve, the counter moves up on taken and down on not taken.
- R5: The choice counter selected by the global history picks the final prediction. An MSB of 1 (values 10 and 11) returns `pred_global` on `pred_taken`, and an MSB of 0 returns `pred_local`.
- R6: On resolve, the choice counter changes only when `res_local` and `res_global` differ. It moves up when `res_global` equals the outcome and down otherwise.
- R7: Every counter saturates at all-ones and at zero and never wraps.
- R8: On resolve, the outcome is shifted into bit 0 of the global history register.
- R9: After reset or a cycle with `ctx_clear` high, every table entry and the global history are zero, so predictions are not taken and the choice selects local. A resolve in the clear cycle is dropped.
- R10: A predict and a resolve in the same cycle are both accepted. The prediction uses the state from before that cycle's update, and the update is visible to a predict in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_clear | input | 1 | Clears all predictor state |
| pred_req | input | 1 | Prediction request strobe |
| pred_pc | input | PC_W | Fetch address of the branch to predict |
| pred_valid | output | 1 | Prediction outputs valid |
| pred_taken | output | 1 | Final taken prediction |
| pred_local | output | 1 | Local component prediction |
| pred_global | output | 1 | Global component prediction |
| res_valid | input | 1 | Resolve strobe |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_local | input | 1 | Local prediction saved at predict time |
| res_global | input | 1 | Global prediction saved at predict time |

## Verification
The bench builds the block with a 10-bit address, a 3-bit local-history index, 4-bit local and global histories, 3-bit local counters and 2-bit global and choice counters. With these sizes a random stream of addresses makes branches alias in the history table. It also lets a dozen resolves of one branch fill a history and push a counter into saturation, and it lets the choice counters cross between local and global many times within a few thousand cycles. The default sizes differ only in table depth and history length, so the same update paths are covered.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Meaning of a choice counter's most significant bit.
    typedef enum logic {
        PICK_LOCAL  = 1'b0,
        PICK_GLOBAL = 1'b1
    } pick_e;

endpackage

// File: rtl/bp_sat_step.sv
module bp_sat_step #(
    parameter int W = 2
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] CMAX = '1;
    localparam logic [W-1:0] CMIN = '0;

    always_comb begin
        nxt = cur;
        if (up) begin
            if (cur != CMAX) nxt = cur + 1'b1;
        end else begin
            if (cur != CMIN) nxt = cur - 1'b1;
        end
    end

    // R7
    always_comb begin
        sat_bound_chk: assert (up ? (nxt >= cur) : (nxt <= cur));
    end
endmodule

// File: rtl/bp_table.sv
module bp_table #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wr_cur
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    assign rd_data = mem_q[rd_idx];
    assign wr_cur  = mem_q[wr_idx];

    always_comb begin
        mem_d = mem_q;
        if (clear) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
        end else if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // R9
    tbl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd_data == '0));

    // R10
    tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear && rd_idx == wr_idx) |=> $stable(rd_idx) |-> (rd_data == $past(wr_data)));
endmodule

// File: rtl/bp_tournament.sv
module bp_tournament
    import bp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10,
    parameter int LCNT_W    = 3,
    parameter int GHIST_W   = 12,
    parameter int GCNT_W    = 2,
    parameter int CHO_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctx_clear,
    input  logic            pred_req,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_valid,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_local,
    input  logic            res_global
);
    typedef struct packed {
        logic [GHIST_W-1:0] ghr;
        logic               vld;
        logic               tkn;
        logic               loc;
        logic               glb;
    } state_t;

    state_t st_d, st_q;

    logic [LHT_IDX_W-1:0] pred_lidx, res_lidx;
    logic [LHIST_W-1:0]   pred_lhist, res_lhist, res_lhist_nxt;
    logic [LCNT_W-1:0]    pred_lctr, res_lctr, res_lctr_nxt;
    logic [GCNT_W-1:0]    pred_gctr, res_gctr, res_gctr_nxt;
    logic [CHO_W-1:0]     pred_cctr, res_cctr, res_cctr_nxt;
    logic                 res_go, cho_wr, cho_up;
    pick_e                pick;

    // XOR-fold every address bit into the history-table index
    always_comb begin
        pred_lidx = '0;
        res_lidx  = '0;
        for (int i = 0; i < PC_W; i++) begin
            pred_lidx[i % LHT_IDX_W] = pred_lidx[i % LHT_IDX_W] ^ pred_pc[i];
            res_lidx[i % LHT_IDX_W]  = res_lidx[i % LHT_IDX_W] ^ res_pc[i];
        end
    end

    assign res_go        = res_valid && !ctx_clear;
    assign cho_wr        = res_go && (res_local != res_global);
    assign cho_up        = (res_global == res_taken);
    assign res_lhist_nxt = {res_lhist[LHIST_W-2:0], res_taken};

    bp_table #(.IDX_W(LHT_IDX_W), .DATA_W(LHIST_W)) u_lht (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(pred_lidx), .rd_data(pred_lhist),
        .wr_en(res_go), .wr_idx(res_lidx), .wr_data(res_lhist_nxt), .wr_cur(res_lhist)
    );

    bp_table #(.IDX_W(LHIST_W), .DATA_W(LCNT_W)) u_lct (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(pred_lhist), .rd_data(pred_lctr),
        .wr_en(res_go), .wr_idx(res_lhist), .wr_data(res_lctr_nxt), .wr_cur(res_lctr)
    );

    bp_table #(.IDX_W(GHIST_W), .DATA_W(GCNT_W)) u_gct (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(st_q.ghr), .rd_data(pred_gctr),
        .wr_en(res_go), .wr_idx(st_q.ghr), .wr_data(res_gctr_nxt), .wr_cur(res_gctr)
    );

    bp_table #(.IDX_W(GHIST_W), .DATA_W(CHO_W)) u_cht (
        .clk(clk), .rst_n(rst_n), .clear(ctx_clear),
        .rd_idx(st_q.ghr), .rd_data(pred_cctr),
        .wr_en(cho_wr), .wr_idx(st_q.ghr), .wr_data(res_cctr_nxt), .wr_cur(res_cctr)
    );

    bp_sat_step #(.W(LCNT_W)) u_lstep (.cur(res_lctr), .up(res_taken), .nxt(res_lctr_nxt));
    bp_sat_step #(.W(GCNT_W)) u_gstep (.cur(res_gctr), .up(res_taken), .nxt(res_gctr_nxt));
    bp_sat_step #(.W(CHO_W))  u_cstep (.cur(res_cctr), .up(cho_up),    .nxt(res_cctr_nxt));

    assign pick = pick_e'(pred_cctr[CHO_W-1]);

    always_comb begin
        st_d     = st_q;
        st_d.vld = pred_req;
        if (pred_req) begin
            st_d.loc = pred_lctr[LCNT_W-1];
            st_d.glb = pred_gctr[GCNT_W-1];
            st_d.tkn = (pick == PICK_GLOBAL) ? pred_gctr[GCNT_W-1] : pred_lctr[LCNT_W-1];
        end
        if (ctx_clear) begin
            st_d.ghr = '0;
        end else if (res_valid) begin
            st_d.ghr = {st_q.ghr[GHIST_W-2:0], res_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_valid  = st_q.vld;
    assign pred_taken  = st_q.tkn;
    assign pred_local  = st_q.loc;
    assign pred_global = st_q.glb;

    // R1
    pred_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> pred_valid);

    // R1
    pred_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req |=> !pred_valid);

    // R5
    agree_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_local == pred_global) |-> (pred_taken == pred_local));

    // R8
    ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_go |=> (st_q.ghr == {$past(st_q.ghr[GHIST_W-2:0]), $past(res_taken)}));

    // R9
    clear_ghr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |=> (st_q.ghr == '0));
endmodule

// File: tb/tb_bp_tournament.sv
module tb_bp_tournament;
    localparam int PC_W = 10, LIW = 3, LHW = 4, LCW = 3, GHW = 4, GCW = 2, CCW = 2;

    logic clk = 1'b0, rst_n = 1'b0, ctx_clear = 1'b0;
    logic pred_req = 1'b0, res_valid = 1'b0, res_taken = 1'b0, res_local = 1'b0, res_global = 1'b0;
    logic [PC_W-1:0] pred_pc = '0, res_pc = '0;
    logic pred_valid, pred_taken, pred_local, pred_global;

    int checks = 0, errors = 0;
    bit done = 0;

    int m_lht [1<<LIW];
    int m_lct [1<<LHW];
    int m_gct [1<<GHW];
    int m_cht [1<<GHW];
    int m_ghr;

    bp_tournament #(.PC_W(PC_W), .LHT_IDX_W(LIW), .LHIST_W(LHW), .LCNT_W(LCW),
                    .GHIST_W(GHW), .GCNT_W(GCW), .CHO_W(CCW)) dut (
        .clk(clk), .rst_n(rst_n), .ctx_clear(ctx_clear),
        .pred_req(pred_req), .pred_pc(pred_pc), .pred_valid(pred_valid),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_local(res_local), .res_global(res_global)
    );

    always #10 clk = ~clk;

    function automatic int fold(input logic [PC_W-1:0] pc);
        int idx = 0;
        for (int i = 0; i < PC_W; i++) idx = idx ^ (int'(pc[i]) << (i % LIW));
        return idx;
    endfunction

    function automatic int sat(input int cur, input bit up, input int w);
        int mx = (1 << w) - 1;
        if (up) return (cur == mx) ? cur : cur + 1;
        return (cur == 0) ? cur : cur - 1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < (1<<LIW); i++) m_lht[i] = 0;
        for (int i = 0; i < (1<<LHW); i++) m_lct[i] = 0;
        for (int i = 0; i < (1<<GHW); i++) begin m_gct[i] = 0; m_cht[i] = 0; end
        m_ghr = 0;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model update, check at the next negedge
    task automatic step(input string ph, input bit req, input logic [PC_W-1:0] pc,
                        input bit rv, input logic [PC_W-1:0] rpc, input bit rt,
                        input bit rl, input bit rg, input bit clr);
        int h, el, eg, ec, et, idx;
        pred_req = req; pred_pc = pc; res_valid = rv; res_pc = rpc;
        res_taken = rt; res_local = rl; res_global = rg; ctx_clear = clr;
        h  = m_lht[fold(pc)];
        el = (m_lct[h] >> (LCW-1)) & 1;
        eg = (m_gct[m_ghr] >> (GCW-1)) & 1;
        ec = (m_cht[m_ghr] >> (CCW-1)) & 1;
        et = ec ? eg : el;
        if (clr) model_clear();
        else if (rv) begin
            idx = fold(rpc);
            h = m_lht[idx];
            m_lct[h] = sat(m_lct[h], rt, LCW);
            m_gct[m_ghr] = sat(m_gct[m_ghr], rt, GCW);
            if (rl != rg) m_cht[m_ghr] = sat(m_cht[m_ghr], rg == rt, CCW);
            m_lht[idx] = ((h << 1) | int'(rt)) & ((1<<LHW)-1);
            m_ghr = ((m_ghr << 1) | int'(rt)) & ((1<<GHW)-1);
        end
        @(negedge clk);
        check({ph, " R1 pred_valid"}, pred_valid, req);
        if (req) begin
            check({ph, " R2 R3 pred_local"}, pred_local, el[0]);
            check({ph, " R4 R8 pred_global"}, pred_global, eg[0]);
            check({ph, " R5 R6 pred_taken"}, pred_taken, et[0]);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20061));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state: everything not taken, choice selects local
        check("R9 reset pred_valid", pred_valid, 1'b0);
        step("R9", 1, 10'h155, 0, 0, 0, 0, 0, 0);

        // R7 saturation up: twelve taken resolves of one branch
        step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 12; i++) step("R7", 0, 0, 1, 10'h021, 1, 1, 1, 0);
        step("R7", 1, 10'h021, 0, 0, 0, 0, 0, 0);
        check("R7 local saturated high", pred_local, 1'b1);
        check("R7 global saturated high", pred_global, 1'b1);
        // saturation down
        for (int i = 0; i < 12; i++) step("R7", 0, 0, 1, 10'h021, 0, 0, 0, 0);
        step("R7", 1, 10'h021, 0, 0, 0, 0, 0, 0);
        check("R7 local saturated low", pred_local, 1'b0);

        // R6 choice moves toward global when only global was right
        step("R9", 0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 6; i++) step("R6", 0, 0, 1, 10'h0F3, 1, 0, 1, 0);
        for (int i = 0; i < 6; i++) step("R6", 1, 10'h0F3, 1, 10'h0F3, 1, 1, 1, 0);
        step("R6", 1, 10'h0F3, 0, 0, 0, 0, 0, 0);

        // R10 predict and resolve on the same branch in one cycle
        for (int i = 0; i < 8; i++) step("R10", 1, 10'h2A7, 1, 10'h2A7, i % 3 != 0, i[0], i[1], 0);

        // R9 resolve during a clear is dropped
        step("R9", 1, 10'h011, 1, 10'h011, 1, 0, 1, 1);
        step("R9", 1, 10'h011, 0, 0, 0, 0, 0, 0);
        check("R9 after clear local", pred_local, 1'b0);
        check("R9 after clear taken", pred_taken, 1'b0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit rq = ($urandom % 4) != 0;
            bit rv = ($urandom % 3) != 0;
            bit cl = ($urandom % 97) == 0;
            logic [PC_W-1:0] p = PC_W'($urandom % 48);
            logic [PC_W-1:0] q = ($urandom % 2) ? p : PC_W'($urandom % 48);
            step("R2 R10", rq, p, rv, q, ($urandom % 5) < 3, $urandom % 2, $urandom % 2, cl);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule